// File: doc/BRIEF.md
# Overwriting Receive Word FIFO with Status Flags

This block holds serial-bus data words that a filter upstream has accepted, until a host reads them. Each accepted 32-bit word arrives with a one-cycle store strobe and is kept whole. The host pops words one at a time with a read strobe. The read data port always presents the oldest word held.

Three status outputs report the occupancy: empty, half (sixteen or more words) and full (thirty-two words). A single flag output mirrors one of these conditions, or a not-empty condition, according to a two-bit select. When the store is full and no pop comes in the same cycle, an incoming word takes the place of the newest stored word. Nothing is dropped from the older entries, and the occupancy does not grow.

Top module: `rx_word_fifo`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, leaves the FIFO with no words: empty=1, half=0, full=0.
- R2: Words leave in the order they were stored, with all 32 bits unchanged. rd_data shows the oldest stored word whenever empty=0.
- R3: empty is 1 exactly when no words are held. It falls on the edge that stores the first word.
- R4: half is 1 exactly when 16 or more words are held.
- R5: full is 1 exactly when 32 words are held.
- R6: A store while full with no pop replaces the newest stored word with the incoming one. The count stays at 32 and the oldest word (rd_data) is unchanged.
- R7: A store and a pop in the same cycle while full act as a normal pop plus a normal append, so no stored word is overwritten.
- R8: A pop while empty is ignored. The FIFO stays empty, and a later store is read back as the oldest word.
- R9: flag_out follows flag_sel: 0 gives empty, 1 gives half, 2 gives full, and 3 gives not-empty.
- R10: The status outputs and rd_data reflect each store or pop from the clock edge that samples the strobe. A store and a pop in the same cycle while words are held leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Store strobe for an accepted word |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | 32 | Oldest stored word |
| empty | output | 1 | No words held |
| half | output | 1 | 16 or more words held |
| full | output | 1 | 32 words held |
| flag_sel | input | 2 | Selects the condition shown on flag_out |
| flag_out | output | 1 | Selected status condition |

## Verification
The hardest condition to reach from the ports is a long run of stores while full. In that run the newest slot must be overwritten repeatedly while the oldest 31 words stay intact. Only a later drain of those 31 words shows which value ended up in the last slot. The stimulus first stores 40 distinct words with no pops, then drains the FIFO and checks each word in order, expecting the 40th word last. A long random phase then mixes stores and pops with biases that keep the occupancy near full. This makes same-cycle pop-and-store while full, and pops while empty, occur many times. A behavioural queue is compared against the outputs on every cycle.

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          half,
  output logic          full,
  input  logic [1:0]    flag_sel,
  output logic          flag_out
);

  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int HALF = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  wire do_pop   = rd_en && !empty;
  wire do_push  = wr_en && (!full || do_pop);
  wire do_ovw   = wr_en && full && !do_pop;
  wire [PW-1:0] wlast = wptr - PW'(1);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr]  <= wr_data;
    if (do_ovw)  mem[wlast] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rptr];
  assign empty   = (count == '0);
  assign half    = (count >= CW'(HALF));
  assign full    = (count == CW'(DEPTH));

  always_comb begin
    case (flag_sel)
      2'd0:    flag_out = empty;
      2'd1:    flag_out = half;
      2'd2:    flag_out = full;
      default: flag_out = !empty;
    endcase
  end

  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> empty && !half && !full);
  assert_last_pop_R3: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(1) && rd_en && !wr_en) |=> empty);
  assert_flag_mix_R4: assert property (@(posedge clk) disable iff (rst)
    !(empty && half) && !(empty && full));
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full);
  assert_overwrite_keeps_oldest_R6: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> $stable(rd_data) && full);
  assert_pop_push_full_R7: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && rd_en) |=> full);
  assert_pop_empty_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> empty);
  assert_first_store_R10: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_en) |=> !empty);

endmodule

// File: tb/rx_word_fifo_tb_top.sv
module rx_word_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  flag_sel = 2'd0;
  logic [31:0] rd_data;
  logic        empty, half, full, flag_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [31:0] q[$];

  always #5 clk = ~clk;

  rx_word_fifo dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .half(half), .full(full),
    .flag_sel(flag_sel), .flag_out(flag_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // behavioural reference queue
  always @(posedge clk) begin
    cyc++;
    if (rst) q.delete();
    else begin
      automatic bit popping = rd_en && q.size() > 0;
      if (popping) void'(q.pop_front());
      if (wr_en) begin
        if (q.size() < 32) q.push_back(wr_data);
        else q[31] = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      automatic int n = q.size();
      automatic logic fexp;
      chk("R3 empty", 32'(empty), 32'(n == 0));
      chk("R4 half",  32'(half),  32'(n >= 16));
      chk("R5 full",  32'(full),  32'(n == 32));
      case (flag_sel)
        2'd0: fexp = (n == 0);
        2'd1: fexp = (n >= 16);
        2'd2: fexp = (n == 32);
        default: fexp = (n != 0);
      endcase
      chk("R9 flag_out", 32'(flag_out), 32'(fexp));
      if (n > 0) chk("R2 rd_data oldest", rd_data, q[0]);
    end
  end

  task automatic step(input bit w, input logic [31:0] d, input bit r, input logic [1:0] s);
    @(posedge clk); #1;
    wr_en = w; wr_data = d; rd_en = r; flag_sel = s;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset empty", 32'(empty), 32'd1);
    chk("R1 reset half", 32'(half), 32'd0);
    chk("R1 reset full", 32'(full), 32'd0);

    for (int i = 0; i < 40; i++) step(1, 32'hA5000000 + 32'(i), 0, 2'(i % 4));
    step(0, 0, 0, 2'd2);
    @(negedge clk);
    chk("R5 full after 40 stores", 32'(full), 32'd1);
    chk("R6 oldest kept", rd_data, 32'hA5000000);
    chk("R9 flag full", 32'(flag_out), 32'd1);

    step(1, 32'h5A5A5A5A, 1, 2'd3);
    step(0, 0, 0, 2'd3);
    @(negedge clk);
    chk("R7 still full", 32'(full), 32'd1);
    chk("R7 next oldest", rd_data, 32'hA5000001);

    for (int i = 0; i < 30; i++) step(0, 0, 1, 2'd1);
    step(0, 0, 0, 2'd1);
    @(negedge clk);
    chk("R6 overwritten slot", rd_data, 32'hA5000027);
    step(0, 0, 1, 2'd0);
    step(0, 0, 0, 2'd0);
    @(negedge clk);
    chk("R7 appended word", rd_data, 32'h5A5A5A5A);
    step(0, 0, 1, 2'd0);
    step(0, 0, 1, 2'd0);
    step(0, 0, 0, 2'd0);
    @(negedge clk);
    chk("R8 empty after pop on empty", 32'(empty), 32'd1);
    step(1, 32'hDEADBEEF, 1, 2'd3);
    step(0, 0, 0, 2'd3);
    @(negedge clk);
    chk("R10 store while empty seen", 32'(empty), 32'd0);
    chk("R8 word after ignored pop", rd_data, 32'hDEADBEEF);

    for (int i = 0; i < 6000; i++) begin
      automatic int ph = (i / 500) % 3;
      automatic int pw = (ph == 0) ? 85 : (ph == 1) ? 50 : 20;
      automatic int pr = (ph == 0) ? 30 : (ph == 1) ? 50 : 80;
      step(($urandom % 100) < pw, $urandom, ($urandom % 100) < pr, 2'($urandom));
    end
    step(0, 0, 0, 2'd0);
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", 32'(empty), 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule